// File: doc/BRIEF.md
# Serial Receive Buffer with Per-Frame Error Flags

This block is the receive half of an asynchronous serial port. An oversampling front end finds the start bit, samples every bit at its centre and assembles one character in a shift holding register. Completed characters then move into a small receive queue. Each queue slot keeps the received byte together with three flags: a framing flag, an overrun flag and a parity flag. Because the flags travel with their own character, software reads the status of the oldest character first and then reads its data. The data read removes that character from the queue.

A receive-complete output is high while the queue holds any character. A level interrupt follows that output whenever the interrupt enable is set. When the receiver enable is cleared, the queue and the holding register are emptied. If both queue slots and the holding register are full when another start bit is confirmed, the new character is dropped. The loss is then reported on the next character that reaches the queue.

Top module: `uart_rx_buffer`

## Requirements
- R1: `rxc` is 1 in every cycle in which the queue holds at least one unread character, and 0 when the queue is empty.
- R2: When `rx_en` is sampled low, the queue, the holding register and any pending overrun are discarded, so `rxc` is 0 from the next cycle on.
- R3: `irq` equals `rxc` AND `irq_en` at all times. The error flags have no influence on `irq`.
- R4: `rx_data`, `stat_fe`, `stat_dor` and `stat_pe` show the oldest unread character. A `data_rd` pulse removes that character and exposes the next one. A `data_rd` with an empty queue changes nothing, and all four outputs read 0 while the queue is empty.
- R5: `stat_wr` with any `stat_wdata` value leaves every stored flag and every output unchanged.
- R6: `stat_fe` is 1 when the first stop bit was sampled as 0, and 0 when it was sampled as 1. Nothing after the first stop bit is examined, so a start bit may follow the first stop bit directly.
- R7: With `par_en`=1, a parity bit follows the data. `stat_pe` is 1 when the parity bit disagrees with the setting of `par_odd`: with `par_odd`=0 the data bits plus the parity bit must hold an even number of ones, and with `par_odd`=1 an odd number. With `par_en`=0 no parity bit is sent and `stat_pe` is 0.
- R8: A character whose start bit is confirmed while both queue slots and the holding register are full, and no `data_rd` occurs in that cycle, is discarded.
- R9: After a loss, the next character that moves from the holding register into the queue carries `stat_dor`=1. Characters that move without a preceding loss carry 0.
- R10: A character in the holding register moves into the queue in the same cycle that a `data_rd` frees a slot.
- R11: A frame is one low start bit, 8 data bits sent LSB first, an optional parity bit and a stop bit, with each bit lasting OSR (16) clock cycles. A start is confirmed only if `rxd` is still low OSR/2 cycles after the falling edge is seen. Bits are sampled OSR cycles apart after that point.
- R12: After reset, `rxc`, `irq`, `rx_data` and all three status flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the oversampling tick |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable; low flushes the buffer |
| par_en | input | 1 | Frame carries a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| irq_en | input | 1 | Receive interrupt enable |
| rxd | input | 1 | Serial line, already synchronous to clk |
| data_rd | input | 1 | Data read strobe; removes the oldest character |
| stat_wr | input | 1 | Status write strobe (has no effect on the flags) |
| stat_wdata | input | 3 | Status write value (ignored) |
| rx_data | output | 8 | Data byte of the oldest character |
| stat_fe | output | 1 | Framing flag of the oldest character |
| stat_dor | output | 1 | Overrun flag of the oldest character |
| stat_pe | output | 1 | Parity flag of the oldest character |
| rxc | output | 1 | Receive complete: the queue is not empty |
| irq | output | 1 | Level receive interrupt |

## Verification
The assertions assume that `rxd` is already synchronous to `clk`. They also assume that `par_en` and `par_odd` stay constant while a frame is on the line, and that `rx_en` is lowered only when the line is idle. The bench drives `rxd` and every control input only on falling clock edges, changes the parity settings only between frames, and toggles `rx_en` only after all scheduled frames have completed. Under these conditions every character completes at a cycle the bench can compute from the moment it started driving that character.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int RX_DW = 8;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_START,
    RS_DATA,
    RS_PAR,
    RS_STOP
  } rx_state_e;

  typedef struct packed {
    logic [RX_DW-1:0] data;
    logic             fe;
    logic             dor;
    logic             pe;
  } rx_entry_t;

  // 1 when the received parity bit disagrees with the selected sense
  function automatic logic parity_mismatch(input logic [RX_DW-1:0] d,
                                           input logic pbit,
                                           input logic odd);
    return (^{d, pbit}) ^ odd;
  endfunction

endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      rxd,
  input  logic      par_en,
  input  logic      par_odd,
  output logic      start_ok,
  output logic      done,
  output rx_entry_t frame
);
  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;
  localparam int BW   = $clog2(RX_DW);

  rx_state_e        st;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bitn;
  logic [RX_DW-1:0] shreg;
  logic             pbit;
  logic             at_half, at_end;

  assign at_half  = (cnt == CW'(HALF - 1));
  assign at_end   = (cnt == CW'(OSR - 1));
  assign start_ok = (st == RS_START) && at_half && !rxd;
  assign done     = (st == RS_STOP) && at_end;

  always_comb begin
    frame.data = shreg;
    frame.fe   = !rxd;
    frame.dor  = 1'b0;
    frame.pe   = par_en && parity_mismatch(shreg, pbit, par_odd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= RS_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= '0;
      pbit  <= 1'b0;
    end else if (!en) begin
      st  <= RS_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        RS_IDLE: begin
          cnt <= '0;
          if (!rxd) st <= RS_START;
        end
        RS_START: begin
          if (at_half) begin
            cnt  <= '0;
            bitn <= '0;
            st   <= rxd ? RS_IDLE : RS_DATA;
          end else cnt <= cnt + CW'(1);
        end
        RS_DATA: begin
          if (at_end) begin
            cnt   <= '0;
            shreg <= {rxd, shreg[RX_DW-1:1]};
            if (bitn == BW'(RX_DW - 1)) st <= par_en ? RS_PAR : RS_STOP;
            else bitn <= bitn + BW'(1);
          end else cnt <= cnt + CW'(1);
        end
        RS_PAR: begin
          if (at_end) begin
            cnt  <= '0;
            pbit <= rxd;
            st   <= RS_STOP;
          end else cnt <= cnt + CW'(1);
        end
        RS_STOP: begin
          if (at_end) begin
            cnt <= '0;
            st  <= RS_IDLE;
          end else cnt <= cnt + CW'(1);
        end
        default: st <= RS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic                        push,
  input  rx_entry_t                   din,
  input  logic                        pop,
  output rx_entry_t                   dout,
  output logic [$clog2(DEPTH+1)-1:0]  level,
  output logic                        full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  rx_entry_t     mem [DEPTH];
  logic [PW-1:0] wr, rd;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign dout = mem[rd];
  assign full = (level == LW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr <= '0; rd <= '0; level <= '0;
    end else if (flush) begin
      wr <= '0; rd <= '0; level <= '0;
    end else begin
      if (push) wr <= step(wr);
      if (pop)  rd <= step(rd);
      case ({push, pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr] <= din;
  end
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import uart_rx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             irq_en,
  input  logic             rxd,
  input  logic             data_rd,
  input  logic             stat_wr,
  input  logic [2:0]       stat_wdata,
  output logic [RX_DW-1:0] rx_data,
  output logic             stat_fe,
  output logic             stat_dor,
  output logic             stat_pe,
  output logic             rxc,
  output logic             irq
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic             start_ok, done;
  rx_entry_t        frame, hold_q, head, push_entry;
  logic             hold_v, dor_pend, doomed;
  logic             fifo_full, pop, xfer, lose;
  logic [LVL_W-1:0] fifo_level;
  logic             unused_stat_wr;

  // status writes are accepted on the bus but reach no flag
  assign unused_stat_wr = ^{stat_wr, stat_wdata};

  uart_rx_sampler #(.OSR(OSR)) u_samp (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .rxd(rxd),
    .par_en(par_en), .par_odd(par_odd),
    .start_ok(start_ok), .done(done), .frame(frame)
  );

  assign pop  = data_rd && rxc;
  assign xfer = hold_v && (!fifo_full || pop);
  assign lose = start_ok && hold_v && fifo_full && !pop;

  always_comb begin
    push_entry     = hold_q;
    push_entry.dor = dor_pend | hold_q.dor;
  end

  uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(!rx_en),
    .push(xfer), .din(push_entry), .pop(pop),
    .dout(head), .level(fifo_level), .full(fifo_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0; hold_v <= 1'b0; dor_pend <= 1'b0; doomed <= 1'b0;
    end else if (!rx_en) begin
      hold_v <= 1'b0; dor_pend <= 1'b0; doomed <= 1'b0;
    end else begin
      if (start_ok)  doomed <= lose;
      else if (done) doomed <= 1'b0;
      if (lose)      dor_pend <= 1'b1;
      else if (xfer) dor_pend <= 1'b0;
      if (done && !doomed) begin
        hold_q <= frame;
        hold_v <= 1'b1;
      end else if (xfer) hold_v <= 1'b0;
    end
  end

  assign rxc      = (fifo_level != '0);
  assign irq      = rxc && irq_en;
  assign rx_data  = rxc ? head.data : '0;
  assign stat_fe  = rxc && head.fe;
  assign stat_dor = rxc && head.dor;
  assign stat_pe  = rxc && head.pe;
endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker #(
  parameter int LW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          irq_en,
  input logic          data_rd,
  input logic          rxc,
  input logic          irq,
  input logic [7:0]    rx_data,
  input logic          hold_v,
  input logic          fifo_full,
  input logic          lose,
  input logic          dor_pend,
  input logic [LW-1:0] level
);
  AST_LAST_POP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && data_rd && level == LW'(1) && !hold_v) |=> !rxc); // R1

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rxc && !hold_v)); // R2

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq |-> (rxc && irq_en)) and ((rxc && irq_en) |-> irq)); // R3

  AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && rxc && !data_rd) |=> (rxc && $stable(rx_data))); // R4

  AST_LOSS_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && lose) |=> dor_pend); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && hold_v && fifo_full && data_rd) |=> !hold_v); // R10
endmodule

bind uart_rx_buffer uart_rx_checker #(.LW(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .irq_en(irq_en),
  .data_rd(data_rd), .rxc(rxc), .irq(irq), .rx_data(rx_data),
  .hold_v(hold_v), .fifo_full(fifo_full), .lose(lose),
  .dor_pend(dor_pend), .level(fifo_level)
);

// File: tb/sim_uart_rx_buffer.sv
module sim_uart_rx_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int OSR  = 16;
  localparam int HALF = OSR / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0, rx_en = 1'b0, par_en = 1'b0, par_odd = 1'b0, irq_en = 1'b0;
  logic rxd = 1'b1, data_rd = 1'b0, stat_wr = 1'b0;
  logic [2:0] stat_wdata = 3'b000;
  logic [7:0] rx_data;
  logic stat_fe, stat_dor, stat_pe, rxc, irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_buffer u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .par_en(par_en), .par_odd(par_odd),
    .irq_en(irq_en), .rxd(rxd), .data_rd(data_rd), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .rx_data(rx_data), .stat_fe(stat_fe),
    .stat_dor(stat_dor), .stat_pe(stat_pe), .rxc(rxc), .irq(irq)
  );

  typedef struct { int data; bit fe; bit dor; bit pe; } ent_t;

  ent_t q[$];
  ent_t hold;
  bit   hold_v = 0, dor_pend = 0, doomed = 0;
  int   conf_q[$];
  int   done_t[$];
  ent_t done_e[$];
  int   ecount = 0;
  int   n_chk = 0, n_fail = 0;
  bit   run_cmp = 0, finished = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // behavioural reference: a queue, a holding slot, scheduled events
  always @(posedge clk) begin
    bit ec, ed, pop, xfer, lose, old_doomed;
    ent_t nx;
    ecount++;
    ec = (conf_q.size() > 0) && (conf_q[0] == ecount);
    ed = (done_t.size() > 0) && (done_t[0] == ecount);
    if (ec) void'(conf_q.pop_front());
    if (!rst_n || !rx_en) begin
      q.delete(); hold_v = 0; dor_pend = 0; doomed = 0;
      if (ed) begin void'(done_t.pop_front()); void'(done_e.pop_front()); end
    end else begin
      pop  = data_rd && (q.size() > 0);
      xfer = hold_v && ((q.size() < 2) || pop);
      lose = ec && hold_v && (q.size() == 2) && !pop;
      nx = hold; nx.dor = dor_pend;
      old_doomed = doomed;
      if (pop)  void'(q.pop_front());
      if (xfer) q.push_back(nx);
      if (lose) dor_pend = 1; else if (xfer) dor_pend = 0;
      if (ec) doomed = lose; else if (ed) doomed = 0;
      if (ed && !old_doomed) begin hold = done_e[0]; hold_v = 1; end
      else if (xfer) hold_v = 0;
      if (ed) begin void'(done_t.pop_front()); void'(done_e.pop_front()); end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (run_cmp) begin
      check("R1 rxc", rxc, q.size() > 0);
      check("R3 irq", irq, (q.size() > 0) && irq_en);
      if (q.size() > 0) begin
        check("R4 rx_data", rx_data, q[0].data);
        check("R6 stat_fe", stat_fe, q[0].fe);
        check("R7 stat_pe", stat_pe, q[0].pe);
        check("R9 stat_dor", stat_dor, q[0].dor);
      end else begin
        check("R4 empty outputs", {rx_data, stat_fe, stat_dor, stat_pe}, 0);
      end
    end
  end

  task automatic hold_bit(input logic v);
    rxd = v;
    repeat (OSR) @(negedge clk);
  endtask

  // called at a falling edge; returns at a falling edge after the stop bit
  task automatic send(input logic [7:0] d, input bit flip, input logic stopv);
    int t0, ones;
    bit pb;
    ent_t e;
    t0 = ecount + 1;
    ones = 0;
    for (int i = 0; i < 8; i++) if (d[i]) ones++;
    pb = par_odd ? ((ones % 2) == 0) : ((ones % 2) == 1);
    e.data = d; e.fe = !stopv; e.dor = 0; e.pe = par_en && flip;
    conf_q.push_back(t0 + HALF);
    done_t.push_back(t0 + HALF + (9 + (par_en ? 1 : 0)) * OSR);
    done_e.push_back(e);
    hold_bit(1'b0);
    for (int i = 0; i < 8; i++) hold_bit(d[i]);
    if (par_en) hold_bit(pb ^ flip);
    hold_bit(stopv);
    rxd = 1'b1;
  endtask

  task automatic rd_pulse();
    data_rd = 1'b1;
    @(negedge clk);
    data_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    check("R12 reset rxc/irq", {rxc, irq}, 0);
    check("R12 reset data/flags", {rx_data, stat_fe, stat_dor, stat_pe}, 0);
    rst_n = 1'b1;
    idle(2);
    check("R12 after release", {rxc, irq, rx_data, stat_fe, stat_dor, stat_pe}, 0);
    run_cmp = 1;
    rx_en = 1'b1; irq_en = 1'b1;
    idle(4);

    // R11 LSB-first, no parity
    send(8'hA5, 0, 1'b1);
    idle(2);
    check("R11 lsb first byte", rx_data, 8'hA5);
    check("R1 rxc after frame", rxc, 1);
    check("R3 irq with enable", irq, 1);
    irq_en = 1'b0; idle(1);
    check("R3 irq masked", irq, 0);
    irq_en = 1'b1;
    rd_pulse(); idle(1);
    check("R1 empty after read", rxc, 0);
    rd_pulse(); idle(1);
    check("R4 read when empty", {rxc, rx_data}, 0);

    // R7 even then odd parity, back-to-back frames (R6 single stop)
    par_en = 1'b1; par_odd = 1'b0;
    send(8'h3C, 0, 1'b1);
    send(8'h3D, 1, 1'b1);
    idle(2);
    check("R7 even good pe", stat_pe, 0);
    rd_pulse(); idle(1);
    check("R7 even bad pe", stat_pe, 1);
    check("R6 back-to-back data", rx_data, 8'h3D);
    // R5 status write ignored while a flagged entry is at the head
    stat_wr = 1'b1; stat_wdata = 3'b000; idle(1);
    stat_wr = 1'b0; idle(1);
    check("R5 write ignored", {stat_pe, rx_data}, {1'b1, 8'h3D});
    rd_pulse();
    par_odd = 1'b1;
    send(8'h81, 0, 1'b1);
    send(8'h07, 1, 1'b1);
    idle(2);
    check("R7 odd good pe", stat_pe, 0);
    rd_pulse(); idle(1);
    check("R7 odd bad pe", stat_pe, 1);
    rd_pulse();
    par_en = 1'b0; par_odd = 1'b0;

    // R6 bad stop bit
    send(8'h5A, 0, 1'b0);
    idle(OSR * 2);
    check("R6 fe set", stat_fe, 1);
    stat_wr = 1'b1; stat_wdata = 3'b111; idle(1);
    stat_wr = 1'b0; idle(1);
    check("R5 flags kept", {stat_fe, stat_dor, stat_pe}, 3'b100);
    rd_pulse(); idle(1);
    check("R6 only one frame", rxc, 0);

    // R11 glitch rejected
    rxd = 1'b0; idle(3); rxd = 1'b1;
    idle(OSR * 12);
    check("R11 glitch ignored", rxc, 0);

    // R8/R9/R10 overrun
    send(8'h11, 0, 1'b1);
    send(8'h22, 0, 1'b1);
    send(8'h33, 0, 1'b1);
    send(8'h44, 0, 1'b1);
    idle(4);
    check("R8 head kept", rx_data, 8'h11);
    rd_pulse(); idle(1);
    check("R10 still two queued", rx_data, 8'h22);
    rd_pulse(); idle(1);
    check("R9 dor on next moved", {stat_dor, rx_data}, {1'b1, 8'h33});
    rd_pulse(); idle(1);
    check("R8 lost frame absent", rxc, 0);
    send(8'h55, 0, 1'b1);
    idle(2);
    check("R9 dor clear again", {stat_dor, rx_data}, {1'b0, 8'h55});
    rd_pulse();

    // R2 flush
    send(8'h66, 0, 1'b1);
    send(8'h77, 0, 1'b1);
    idle(2);
    rx_en = 1'b0; idle(2);
    check("R2 flushed", {rxc, irq}, 0);
    rx_en = 1'b1; idle(3);
    check("R2 stays empty", rxc, 0);

    idle(5);
    finish_run();
  end
endmodule